// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides, in the same cycle as the request, whether one physical access may go ahead. The access can be an instruction fetch, a load or a store. It holds a parameterised bank of protection entries. Each entry describes one naturally aligned region, at a granularity of 4 KB, and carries independent read, write and execute grants. A register write port selects an entry by index and writes either that entry's configuration byte or its address word.

The checker takes the current privilege level and the memory-privilege override bit with its saved-privilege field. From these it works out the privilege level that applies to the access. Supervisor and user accesses are always checked. Machine-mode accesses are checked only through locked entries, and loads and stores can also be checked under the saved privilege when the override is set. When a request is valid, exactly one of allow or a type-specific fault comes out.

Top module: `pmp_checker`

## Requirements
- R1: After reset every entry is off and unlocked. A valid supervisor or user access then faults, and a valid machine-mode access is allowed.
- R2: The configuration byte is decoded as: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 match mode (0 off, 1 top-of-range, 2 single page, 3 naturally aligned power of two), bit 7 lock. The address word holds access address bits 31:2. In mode 3, k trailing ones in the address word select a region of 2^(k+3) bytes. Any region smaller than 4 KB is widened to the enclosing 4 KB page, so address bits 11:0 never affect matching.
- R3: Mode 2 matches exactly the 4 KB page that contains the address word shifted left by two.
- R4: Writing match mode 1 stores the entry as off. The entry then matches no address.
- R5: A matched entry grants a fetch only with execute set, a load only with read set, and a store only with write set. Access type codes are 0 fetch, 1 load and 2 store.
- R6: When several entries match, the lowest-numbered one alone decides the outcome.
- R7: With privilege codes 0 user, 1 supervisor and 3 machine, a supervisor or user access that matches no entry faults.
- R8: In machine mode, a load or store with the override bit set is checked as if made at the saved privilege. If the saved privilege is machine, the access is treated as a machine-mode access. Fetches ignore the override bit. A machine-mode access that matches an unlocked entry, or matches no entry, is allowed.
- R9: Once an entry is locked, writes to its configuration and to its address are ignored until reset.
- R10: A locked entry's grants also apply to machine-mode accesses that it matches.
- R11: Outputs are combinational. With the request valid, exactly one of allow, fetch fault, load fault or store fault is high, and a fault is raised only on the output for the request's type. With the request not valid, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the entry registers |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_is_addr_i | input | 1 | 1 writes the address word, 0 writes the configuration byte |
| wr_idx_i | input | 4 | Entry index for the write |
| wr_data_i | input | 30 | Write data (configuration in bits 7:0) |
| req_valid_i | input | 1 | Access request present |
| req_addr_i | input | 32 | Physical access address |
| req_type_i | input | 2 | 0 fetch, 1 load, 2 store |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| mprv_i | input | 1 | Memory-privilege override bit |
| mpp_i | input | 2 | Saved privilege used by the override |
| allow_o | output | 1 | Access permitted |
| fault_fetch_o | output | 1 | Fetch denied |
| fault_load_o | output | 1 | Load denied |
| fault_store_o | output | 1 | Store denied |

## Verification
The assertions assume that the access type is never the unused code 3, and that the privilege and saved-privilege inputs carry only the user, supervisor or machine codes. The machine-fetch property also assumes that entries are locked only through the write port after reset. The random stimulus draws access types modulo three and draws privileges from the three legal codes, so every request stays inside these assumptions. Addresses are drawn around four programmed bases so that matches, overlaps and misses all occur often. A few directed sequences then cover locking, the top-of-range write and the override rules.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [1:0] MODE_OFF   = 2'd0;
  localparam logic [1:0] MODE_TOR   = 2'd1;
  localparam logic [1:0] MODE_PAGE  = 2'd2;
  localparam logic [1:0] MODE_NAPOT = 2'd3;

  // configuration byte field positions (software-visible)
  localparam int CFG_R    = 0;
  localparam int CFG_W    = 1;
  localparam int CFG_X    = 2;
  localparam int CFG_MLO  = 3;
  localparam int CFG_MHI  = 4;
  localparam int CFG_LOCK = 7;

  typedef struct packed {
    logic       lock;
    logic [1:0] mode;
    logic       x;
    logic       w;
    logic       r;
  } entry_cfg_t;
endpackage

// File: rtl/pmp_entry_regs.sv
module pmp_entry_regs
  import pmp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              addr_we_i,
  input  logic [ADDR_W-3:0] wdata_i,
  output entry_cfg_t        cfg_o,
  output logic [ADDR_W-3:0] addr_o
);
  entry_cfg_t        cfg_q, cfg_d;
  logic [ADDR_W-3:0] addr_q;

  always_comb begin
    cfg_d.r    = wdata_i[CFG_R];
    cfg_d.w    = wdata_i[CFG_W];
    cfg_d.x    = wdata_i[CFG_X];
    cfg_d.lock = wdata_i[CFG_LOCK];
    // top-of-range is not supported: store as off
    if (wdata_i[CFG_MHI:CFG_MLO] == MODE_TOR) cfg_d.mode = MODE_OFF;
    else                                       cfg_d.mode = wdata_i[CFG_MHI:CFG_MLO];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else if (!cfg_q.lock) begin
      if (cfg_we_i)  cfg_q  <= cfg_d;
      if (addr_we_i) addr_q <= wdata_i;
    end
  end

  assign cfg_o  = cfg_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/pmp_region_match.sv
module pmp_region_match
  import pmp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-3:0] base_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int WW   = ADDR_W - 2;
  localparam int GRAN = PAGE_BITS - 2;

  logic [WW-1:0] word, base_inc, care_napot, care_page, care;
  logic          unused_addr_lsb;

  assign word            = addr_i[ADDR_W-1:2];
  assign base_inc        = base_i + WW'(1);
  assign unused_addr_lsb = ^addr_i[1:0];

  always_comb begin
    // trailing ones plus the next zero are don't-care
    care_napot = ~(base_i ^ base_inc);
    care_napot[GRAN-1:0] = '0;
    care_page  = '1;
    care_page[GRAN-1:0] = '0;
    unique case (mode_i)
      MODE_NAPOT: care = care_napot;
      MODE_PAGE:  care = care_page;
      default:    care = '0;
    endcase
    hit_o = (mode_i == MODE_NAPOT || mode_i == MODE_PAGE) &&
            ((word & care) == (base_i & care));
  end
endmodule

// File: rtl/pmp_prio_sel.sv
module pmp_prio_sel #(
  parameter int N    = 16,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  hit_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = IW'(i);
    end
    any_o = |hit_i;
  end
endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int PAGE_BITS   = 12,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_is_addr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-3:0] wr_data_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_type_i,
  input  logic [1:0]        priv_i,
  input  logic              mprv_i,
  input  logic [1:0]        mpp_i,
  output logic              allow_o,
  output logic              fault_fetch_o,
  output logic              fault_load_o,
  output logic              fault_store_o
);
  entry_cfg_t              cfg_arr  [NUM_ENTRIES];
  logic [ADDR_W-3:0]       addr_arr [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0]  hit_vec, lock_vec, tor_vec;
  logic                    any_hit;
  logic [IDX_W-1:0]        sel_idx;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(i));

    pmp_entry_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_we_i  (sel && !wr_is_addr_i),
      .addr_we_i (sel &&  wr_is_addr_i),
      .wdata_i   (wr_data_i),
      .cfg_o     (cfg_arr[i]),
      .addr_o    (addr_arr[i])
    );

    pmp_region_match #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_match (
      .mode_i (cfg_arr[i].mode),
      .base_i (addr_arr[i]),
      .addr_i (req_addr_i),
      .hit_o  (hit_vec[i])
    );

    assign lock_vec[i] = cfg_arr[i].lock;
    assign tor_vec[i]  = (cfg_arr[i].mode == MODE_TOR);
  end

  pmp_prio_sel #(.N(NUM_ENTRIES)) u_prio (
    .hit_i (hit_vec),
    .any_o (any_hit),
    .idx_o (sel_idx)
  );

  entry_cfg_t sel_cfg;
  logic [1:0] eff_priv;
  logic       eff_m, perm_ok, legal_type, granted, deny;

  always_comb begin
    sel_cfg  = cfg_arr[sel_idx];
    // override applies to data accesses only
    eff_priv = (req_type_i != ACC_FETCH && priv_i == PRIV_M && mprv_i) ? mpp_i : priv_i;
    eff_m    = (eff_priv == PRIV_M);
    legal_type = (req_type_i != 2'd3);
    unique case (req_type_i)
      ACC_FETCH: perm_ok = sel_cfg.x;
      ACC_LOAD:  perm_ok = sel_cfg.r;
      ACC_STORE: perm_ok = sel_cfg.w;
      default:   perm_ok = 1'b0;
    endcase
    if (any_hit) granted = (eff_m && !sel_cfg.lock) || perm_ok;
    else         granted = eff_m;
    deny = req_valid_i && legal_type && !granted;
  end

  assign allow_o       = req_valid_i && legal_type && granted;
  assign fault_fetch_o = deny && (req_type_i == ACC_FETCH);
  assign fault_load_o  = deny && (req_type_i == ACC_LOAD);
  assign fault_store_o = deny && (req_type_i == ACC_STORE);
endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_valid_i,
  input logic [1:0]             req_type_i,
  input logic [1:0]             priv_i,
  input logic                   allow_o,
  input logic                   fault_fetch_o,
  input logic                   fault_load_o,
  input logic                   fault_store_o,
  input logic [NUM_ENTRIES-1:0] lock_vec,
  input logic [NUM_ENTRIES-1:0] tor_vec,
  input logic [NUM_ENTRIES-1:0] hit_vec
);
  p_one_outcome_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({allow_o, fault_fetch_o, fault_load_o, fault_store_o}));

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !(allow_o || fault_fetch_o || fault_load_o || fault_store_o));

  p_fault_kind_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_fetch_o |-> req_type_i == ACC_FETCH) and
    (fault_load_o  |-> req_type_i == ACC_LOAD)  and
    (fault_store_o |-> req_type_i == ACC_STORE));

  p_no_tor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tor_vec == '0);

  p_lock_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_vec & $past(lock_vec)) == $past(lock_vec));

  p_nomatch_deny_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && priv_i != PRIV_M && hit_vec == '0) |-> !allow_o);

  p_mfetch_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && priv_i == PRIV_M && req_type_i == ACC_FETCH && lock_vec == '0)
      |-> allow_o);
endmodule

bind pmp_checker pmp_checker_sva #(.NUM_ENTRIES(NUM_ENTRIES)) u_pmp_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_type_i    (req_type_i),
  .priv_i        (priv_i),
  .allow_o       (allow_o),
  .fault_fetch_o (fault_fetch_o),
  .fault_load_o  (fault_load_o),
  .fault_store_o (fault_store_o),
  .lock_vec      (lock_vec),
  .tor_vec       (tor_vec),
  .hit_vec       (hit_vec)
);

// File: tb/tb_pmp_checker.sv
module tb_pmp_checker;
  localparam int CLK_PERIOD = 10;
  localparam int NUM = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_is_addr_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic [29:0] wr_data_i = '0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_type_i = '0, priv_i = '0, mpp_i = '0;
  logic        mprv_i = 1'b0;
  logic        allow_o, fault_fetch_o, fault_load_o, fault_store_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0]  m_cfg  [NUM];
  logic [29:0] m_addr [NUM];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pmp_checker #(.NUM_ENTRIES(NUM)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_is_addr_i(wr_is_addr_i),
    .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .req_valid_i(req_valid_i),
    .req_addr_i(req_addr_i), .req_type_i(req_type_i), .priv_i(priv_i),
    .mprv_i(mprv_i), .mpp_i(mpp_i), .allow_o(allow_o), .fault_fetch_o(fault_fetch_o),
    .fault_load_o(fault_load_o), .fault_store_o(fault_store_o)
  );

  task automatic model_clear();
    for (int i = 0; i < NUM; i++) begin
      m_cfg[i] = '0;
      m_addr[i] = '0;
    end
  endtask

  function automatic logic [3:0] expect_out(logic v, logic [31:0] a, logic [1:0] t,
                                            logic [1:0] p, logic mprv, logic [1:0] mpp);
    logic [1:0] ep, mode;
    logic em, found, ok, perm;
    int k, lo;
    if (!v) return 4'b0000;
    ep = (t != 2'd0 && p == 2'd3 && mprv) ? mpp : p;
    em = (ep == 2'd3);
    found = 0;
    ok = em;
    for (int i = 0; i < NUM; i++) begin
      if (!found) begin
        mode = m_cfg[i][4:3];
        if (mode == 2'd2 || mode == 2'd3) begin
          lo = 10;
          if (mode == 2'd3) begin
            k = 0;
            while (k < 30 && m_addr[i][k]) k++;
            if (k + 1 > lo) lo = k + 1;
          end
          if (({2'b00, a[31:2]} >> lo) == ({2'b00, m_addr[i]} >> lo)) begin
            found = 1;
            perm = (t == 2'd0) ? m_cfg[i][2] : (t == 2'd1) ? m_cfg[i][0] : m_cfg[i][1];
            ok = (em && !m_cfg[i][7]) || perm;
          end
        end
      end
    end
    return ok ? 4'b1000 : {1'b0, t == 2'd0, t == 2'd1, t == 2'd2};
  endfunction

  task automatic check(string tag, logic [3:0] exp);
    logic [3:0] act;
    act = {allow_o, fault_fetch_o, fault_load_o, fault_store_o};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {allow,ff,lf,sf} got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(logic is_addr, int idx, logic [29:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_is_addr_i = is_addr; wr_idx_i = 4'(idx); wr_data_i = d;
    if (!m_cfg[idx][7]) begin
      if (is_addr) m_addr[idx] = d;
      else begin
        m_cfg[idx] = d[7:0];
        if (d[4:3] == 2'd1) m_cfg[idx][4:3] = 2'd0;
      end
    end
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
  endtask

  task automatic acc(string tag, logic v, logic [31:0] a, logic [1:0] t,
                     logic [1:0] p, logic mprv, logic [1:0] mpp);
    @(negedge clk_i);
    req_valid_i = v; req_addr_i = a; req_type_i = t; priv_i = p; mprv_i = mprv; mpp_i = mpp;
    #1 check(tag, expect_out(v, a, t, p, mprv, mpp));
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    model_clear();
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1 reset state
    acc("R1 S load after reset", 1, 32'h8000_0000, 2'd1, 2'd1, 0, 2'd0);
    check("R1 reset S load faults", 4'b0010);
    acc("R1 M store after reset", 1, 32'h8000_0000, 2'd2, 2'd3, 0, 2'd0);
    check("R1 reset M store allowed", 4'b1000);
    // R2 napot 64KB, read only
    wr(1, 0, 30'h2000_1FFF);
    wr(0, 0, 30'h19);
    acc("R2 napot top inside", 1, 32'h8000_FFFC, 2'd1, 2'd0, 0, 2'd0);
    check("R2 inside 64KB", 4'b1000);
    acc("R2 napot just above", 1, 32'h8001_0000, 2'd1, 2'd0, 0, 2'd0);
    acc("R5 store denied by R only", 1, 32'h8000_0000, 2'd2, 2'd0, 0, 2'd0);
    check("R5 store fault", 4'b0001);
    acc("R5 fetch denied by R only", 1, 32'h8000_0100, 2'd0, 2'd1, 0, 2'd0);
    // R2 napot widened to 4KB
    wr(1, 1, 30'h2400_0000);
    wr(0, 1, 30'h1F);
    acc("R2 small napot widened", 1, 32'h9000_0FF0, 2'd1, 2'd0, 0, 2'd0);
    check("R2 widened to page", 4'b1000);
    acc("R2 next page miss", 1, 32'h9000_1000, 2'd1, 2'd0, 0, 2'd0);
    // R3 single page
    wr(1, 2, 30'h2800_0123);
    wr(0, 2, 30'h12);
    acc("R3 page last word", 1, 32'hA000_0FFC, 2'd2, 2'd1, 0, 2'd0);
    check("R3 page store allowed", 4'b1000);
    acc("R3 page below", 1, 32'h9FFF_FFFC, 2'd2, 2'd1, 0, 2'd0);
    acc("R3 page above", 1, 32'hA000_1000, 2'd2, 2'd1, 0, 2'd0);
    // R4 tor stays off
    wr(1, 3, 30'h3FFF_FFFF);
    wr(0, 3, 30'h0F);
    acc("R4 tor entry off", 1, 32'hD000_0000, 2'd1, 2'd0, 0, 2'd0);
    check("R4 tor no match", 4'b0010);
    // R6 priority
    wr(1, 4, 30'h2C00_0000);
    wr(0, 4, 30'h10);
    wr(1, 5, 30'h2C00_1FFF);
    wr(0, 5, 30'h1F);
    acc("R6 lower index wins", 1, 32'hB000_0010, 2'd1, 2'd0, 0, 2'd0);
    check("R6 entry4 denies", 4'b0010);
    acc("R6 only entry5", 1, 32'hB000_1000, 2'd1, 2'd0, 0, 2'd0);
    check("R6 entry5 allows", 4'b1000);
    // R8 machine mode and override
    acc("R8 M fetch unlocked", 1, 32'h8000_0000, 2'd0, 2'd3, 0, 2'd0);
    check("R8 M fetch allowed", 4'b1000);
    acc("R8 mprv U store", 1, 32'h8000_0000, 2'd2, 2'd3, 1, 2'd0);
    check("R8 mprv U store fault", 4'b0001);
    acc("R8 mprv S load", 1, 32'h8000_0000, 2'd1, 2'd3, 1, 2'd1);
    acc("R8 mprv M store", 1, 32'h8000_0000, 2'd2, 2'd3, 1, 2'd3);
    acc("R8 mprv ignored for fetch", 1, 32'hD000_0000, 2'd0, 2'd3, 1, 2'd0);
    check("R8 fetch allowed despite mprv", 4'b1000);
    // R10 and R9 lock
    wr(1, 6, 30'h3000_01FF);
    wr(0, 6, 30'h99);
    acc("R10 locked M store", 1, 32'hC000_0000, 2'd2, 2'd3, 0, 2'd0);
    check("R10 M store fault", 4'b0001);
    acc("R10 locked M fetch", 1, 32'hC000_0800, 2'd0, 2'd3, 0, 2'd0);
    acc("R10 locked M load", 1, 32'hC000_0800, 2'd1, 2'd3, 0, 2'd0);
    wr(0, 6, 30'h1F);
    wr(1, 6, 30'h0);
    acc("R9 cfg write ignored", 1, 32'hC000_0000, 2'd2, 2'd3, 0, 2'd0);
    check("R9 still faults", 4'b0001);
    acc("R9 addr write ignored", 1, 32'h0000_0000, 2'd1, 2'd1, 0, 2'd0);
    check("R9 addr unchanged", 4'b0010);
    // R11 idle
    acc("R11 invalid quiet", 0, 32'hC000_0000, 2'd2, 2'd0, 0, 2'd0);
    check("R11 all low", 4'b0000);
    // reset clears locks
    do_reset();
    acc("R9 reset clears lock", 1, 32'hC000_0000, 2'd2, 2'd3, 0, 2'd0);
    check("R1 M allowed after reset", 4'b1000);

    // random phase (R2 R3 R5 R6 R7 R8 R10 R11)
    for (int n = 0; n < 1500; n++) begin
      int r, sel;
      logic [1:0] pr, pp;
      r = int'($urandom % 4);
      sel = int'($urandom % 4) + 8;
      if (r == 0) begin
        if ($urandom % 2 == 0) begin
          wr(1, int'($urandom % NUM), 30'((sel << 26) | ($urandom & 32'h3FFF)));
        end else begin
          logic [7:0] c;
          c = 8'($urandom) & 8'h1F;
          if ($urandom % 12 == 0) c[7] = 1'b1;
          wr(0, int'($urandom % NUM), {22'd0, c});
        end
      end else begin
        pr = ($urandom % 3 == 2) ? 2'd3 : 2'($urandom % 2);
        pp = ($urandom % 3 == 2) ? 2'd3 : 2'($urandom % 2);
        acc("R5 R6 R8 random access", ($urandom % 8) != 0,
            32'((sel << 28) | ($urandom & 32'h0003_FFFF)),
            2'($urandom % 3), pr, 1'($urandom), pp);
      end
    end
    finish_run();
  end
endmodule